// File: doc/BRIEF.md
# Overflow-Reload PWM Timer

This block produces a pulse-width modulated waveform from a free-running up-counter. The counter starts at a programmed reload value and counts toward all-ones. After all-ones it wraps back to the reload value, so the reload value sets the period. A second programmed value, the match point, sets where the active phase ends. The active phase begins at each reload and lasts through the cycle in which the counter equals the match point. The output then stays inactive until the wrap.

Software works out the two values as reload = all-ones − P + 1 and match = reload + D − 1, where P is the period in cycles and D is the active time in cycles. It writes them while the timer is stopped and then raises the run input. Writes that arrive while the timer runs are dropped, so a period already under way cannot be corrupted. A one-cycle strobe marks the last cycle of every period.

Top module: `ovr_pwm_timer`

## Requirements
- R1: After reset the output and the strobe are low, the reload value and the match value are both all-ones minus one, and the timer is stopped.
- R2: On the first clock edge with run high while stopped, the counter takes the reload value. From the next cycle the output is high if match ≥ reload.
- R3: A running period lasts (all-ones − reload + 1) cycles. After the all-ones cycle, the counter reloads the reload value.
- R4: Counted from each reload, the output is high for (match − reload + 1) cycles and low for the remaining (all-ones − match) cycles.
- R5: The strobe is high for exactly the one cycle in which the counter holds all-ones, which is the last cycle of each period.
- R6: If match < reload, the output is low for the whole period. If match = all-ones, the output is high for the whole period.
- R7: One edge after run is sampled low, the output and the strobe are low and stay low while stopped. Writes made while stopped take effect at the next start.
- R8: Writes to the reload value or the match value on an edge where the timer is running are ignored. The waveform continues unchanged.
- R9: A reload value of all-ones minus one gives a two-cycle period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | High to count, low to stop |
| load_we | input | 1 | Write strobe for the reload value |
| load_data | input | W | New reload value |
| match_we | input | 1 | Write strobe for the match value |
| match_data | input | W | New match value |
| pwm_out | output | 1 | PWM waveform, high in the active phase |
| ovf_pulse | output | 1 | One-cycle strobe in the all-ones cycle |

## Verification
The hardest situation to reach from the ports is the edge between two periods. At that edge the counter leaves all-ones and must pick up exactly the reload value, with the period length and active length the requirements give. Each table entry programs a period and a duty, starts the timer, and compares every cycle of two full periods against a pattern computed from the cycle index. This exercises the wrap repeatedly at periods as short as two cycles and at duties of zero and of the full period. Register writes are also issued in the middle of a running waveform, and the following periods must keep the old pattern.

// File: rtl/ovr_pwm_timer.sv
module ovr_pwm_timer #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         load_we,
  input  logic [W-1:0] load_data,
  input  logic         match_we,
  input  logic [W-1:0] match_data,
  output logic         pwm_out,
  output logic         ovf_pulse
);
  localparam logic [W-1:0] TOP     = '1;
  localparam logic [W-1:0] RST_VAL = TOP - 1'b1;

  logic [W-1:0] cnt, load_reg, match_reg;
  logic         running;

  always_ff @(posedge clk) begin
    if (rst) begin
      load_reg  <= RST_VAL;
      match_reg <= RST_VAL;
    end else if (!running) begin
      if (load_we)  load_reg  <= load_data;
      if (match_we) match_reg <= match_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      running <= 1'b0;
    end else if (!run) begin
      running <= 1'b0;
    end else if (!running || cnt == TOP) begin
      cnt     <= load_reg;
      running <= 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign ovf_pulse = running && (cnt == TOP);
  assign pwm_out   = running && (cnt >= load_reg) && (cnt <= match_reg);

  assert_idle_low_R7: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!pwm_out && !ovf_pulse));
  assert_reload_after_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (ovf_pulse && run) |=> (cnt == $past(load_reg)));
  assert_start_level_R2: assert property (@(posedge clk) disable iff (rst)
    (run && !running) |=> (pwm_out == (match_reg >= load_reg)));
  assert_held_while_running_R8: assert property (@(posedge clk) disable iff (rst)
    (running && (load_we || match_we)) |=> ($stable(load_reg) && $stable(match_reg)));
  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (rst)
    (ovf_pulse && run && load_reg != TOP) |=> !ovf_pulse);
  assert_full_duty_R6: assert property (@(posedge clk) disable iff (rst)
    (running && match_reg == TOP && cnt >= load_reg) |-> pwm_out);
endmodule

// File: tb/ovr_pwm_timer_tb_top.sv
`timescale 1ns/1ps
module ovr_pwm_timer_tb_top;
  localparam int W = 32;
  localparam logic [W-1:0] TOP = '1;
  localparam int NV = 7;
  localparam int unsigned VP [NV] = '{4, 2, 5, 6, 7, 3, 9};
  localparam int unsigned VD [NV] = '{2, 1, 0, 6, 3, 1, 8};

  logic clk = 1'b0;
  logic rst, run, load_we, match_we;
  logic [W-1:0] load_data, match_data;
  logic pwm_out, ovf_pulse;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ovr_pwm_timer #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .run(run),
    .load_we(load_we), .load_data(load_data),
    .match_we(match_we), .match_data(match_data),
    .pwm_out(pwm_out), .ovf_pulse(ovf_pulse));

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [W-1:0] ld, input logic [W-1:0] mt);
    load_we = 1; match_we = 1; load_data = ld; match_data = mt;
    tick();
    load_we = 0; match_we = 0;
  endtask

  task automatic observe(input int p, input int d, input int cycles,
                         input string tag, input bit poke);
    int bad = 0;
    int ap = 0, ep = 0;
    for (int k = 0; k < cycles; k++) begin
      bit ep_b = (k % p) < d;
      bit eo_b = (k % p) == p - 1;
      if (pwm_out !== ep_b || ovf_pulse !== eo_b) begin
        if (bad == 0) begin ap = {pwm_out, ovf_pulse}; ep = {ep_b, eo_b}; end
        bad++;
      end
      if (poke && k == 1) begin
        load_we = 1; match_we = 1; load_data = 32'h10; match_data = 32'h5;
      end else begin
        load_we = 0; match_we = 0;
      end
      tick();
    end
    load_we = 0; match_we = 0;
    chk(bad == 0, tag, ap, ep);
  endtask

  task automatic stop_chk();
    run = 0;
    tick();
    chk(!pwm_out && !ovf_pulse, "R7 outputs low when stopped", {pwm_out, ovf_pulse}, 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst = 1; run = 0; load_we = 0; match_we = 0; load_data = '0; match_data = '0;
    tick(); tick();
    rst = 0;
    chk(!pwm_out && !ovf_pulse, "R1 reset outputs", {pwm_out, ovf_pulse}, 0);
    run = 1; tick();
    observe(2, 1, 6, "R1 R9 default two-cycle period", 0);
    stop_chk();

    for (int i = 0; i < NV; i++) begin
      logic [W-1:0] ld, mt;
      ld = TOP - VP[i] + 1;
      mt = ld + VD[i] - 1;
      wr(ld, mt);
      run = 1; tick();
      observe(VP[i], VD[i], 2 * VP[i], "R2 R3 R4 R5 R6 table vector", 0);
      stop_chk();
    end

    wr(TOP - 1, TOP);
    run = 1; tick();
    observe(2, 2, 6, "R9 R6 min load full duty", 0);
    stop_chk();

    wr(TOP - 5, 32'h7);
    run = 1; tick();
    observe(6, 0, 12, "R6 match far below load", 0);
    stop_chk();

    wr(TOP - 3, TOP - 2);
    run = 1; tick();
    observe(4, 2, 16, "R8 writes while running ignored", 1);
    stop_chk();
    repeat (3) begin
      tick();
      chk(!pwm_out && !ovf_pulse, "R7 stays low while stopped", {pwm_out, ovf_pulse}, 0);
    end

    wr(TOP - 2, TOP - 2);
    run = 1; tick();
    observe(3, 1, 9, "R7 stopped write used at restart", 0);
    stop_chk();

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule